// File: doc/BRIEF.md
# Auto-Ranging 16x Sample Tick Generator

This block produces the one-cycle sample enable that clocks the oversampling logic of an asynchronous character path at sixteen times the synchronous bit rate. It runs in a reference clock domain. The tick comes from one of two sources, picked by a static timing-select strap.

In automatic mode the block times one period of the incoming synchronous bit clock against the reference clock. It picks the nearest of ten supported divide ratios and divides the reference clock by that ratio. Three of the ratios are fractional. Each of these is made by cycling through a short, fixed pattern of integer divide counts, so that the average spacing between ticks is exact. The reference clock is meant to run at 128 times the fastest supported bit clock.

In external mode the tick is taken from an external clock that already runs at sixteen times the bit rate. That clock is synchronised into the reference domain and reduced to one tick per rising edge.

Top module: `gen16_tick_gen`

## Requirements
- R1: `ratio_idx` encodes the divide ratio as follows: 0 is 8, 1 is 16, 2 is 21 1/3, 3 is 25 3/5, 4 is 32, 5 is 42 2/3, 6 is 64, 7 is 128, 8 is 256 and 9 is 512.
- R2: With `auto_sel` high and an integer ratio selected, successive ticks are exactly that many reference cycles apart.
- R3: The fractional ratios repeat fixed patterns of tick spacings. For 21 1/3 the pattern is 21, 21, 22, which sums to 64 over 3 ticks. For 25 3/5 it is 26, 25, 26, 25, 26, which sums to 128 over 5 ticks. For 42 2/3 it is 43, 43, 42, which sums to 128 over 3 ticks.
- R4: A measurement is the number D of reference cycles between two rising edges of `bit_clk`. The candidate index is the ratio nearest to D/16, and an exact tie goes to the larger ratio.
- R5: `ratio_idx` changes only when two consecutive measurements give the same candidate. A single measurement that disagrees leaves the ratio unchanged.
- R6: With `auto_sel` low, exactly one tick appears for each rising edge of `ext_clk16`. If that edge is launched half a cycle before a reference edge, the tick is visible three cycles later. The divider produces no ticks in this mode.
- R7: `tick` is never high for two consecutive cycles while `auto_sel` is steady.
- R8: While `rst_n` is low, `tick` is 0 and `ratio_idx` is 0.
- R9: While `bit_clk` is stopped, `ratio_idx` holds its value. The period counter saturates and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| auto_sel | input | 1 | Timing select: 1 selects the automatic divider, 0 selects the external 16x clock (static strap) |
| bit_clk | input | 1 | Synchronous bit clock, asynchronous to `clk` |
| ext_clk16 | input | 1 | External 16x clock, asynchronous to `clk` |
| tick | output | 1 | One-cycle 16x sample enable |
| ratio_idx | output | 4 | Currently selected divide ratio (encoding in R1) |

## Verification
Two things can land in the same cycle: a ratio update coming out of the agreement filter, and the fractional divider reloading its count at a tick boundary. In that cycle the new ratio must be applied starting from a valid point in its pattern. To provoke this, the bench sweeps the ratios in random order with a random bit-clock jitter of up to 2%, so each update arrives at an arbitrary divider phase. After each update it checks every spacing and the sum over each full pattern. The bench also injects a single short bit period to check that a lone disagreeing measurement does not move the ratio.

// File: rtl/gen16_pkg.sv
// Shared constants and lookup functions for the 16x tick generator.
// Assumes ten fixed ratios; the index encoding is the one seen at the top port.
package gen16_pkg;
    localparam int unsigned NUM_RATIOS = 10;
    localparam int unsigned IDX_W      = 4;
    localparam int unsigned PH_W       = 3;
    localparam int unsigned DIV_W      = 10;

    typedef logic [IDX_W-1:0] ratio_idx_t;

    // Number of divide counts in the repeating pattern of a ratio
    function automatic logic [PH_W-1:0] pattern_len(input ratio_idx_t idx);
        case (idx)
            4'd2:    return 3'd3;
            4'd3:    return 3'd5;
            4'd5:    return 3'd3;
            default: return 3'd1;
        endcase
    endfunction

    // Integer divide count used at a given pattern step
    function automatic logic [DIV_W-1:0] divide_count(input ratio_idx_t idx,
                                                      input logic [PH_W-1:0] ph);
        case (idx)
            4'd0:    return 10'd8;
            4'd1:    return 10'd16;
            4'd2:    return (ph == 3'd2) ? 10'd22 : 10'd21;
            4'd3:    return (ph == 3'd1 || ph == 3'd3) ? 10'd25 : 10'd26;
            4'd4:    return 10'd32;
            4'd5:    return (ph == 3'd2) ? 10'd42 : 10'd43;
            4'd6:    return 10'd64;
            4'd7:    return 10'd128;
            4'd8:    return 10'd256;
            default: return 10'd512;
        endcase
    endfunction

    // Smallest bit period (reference cycles) that selects ratio k+1 over ratio k
    function automatic int unsigned period_threshold(input int unsigned k);
        case (k)
            0:       return 192;
            1:       return 299;
            2:       return 376;
            3:       return 461;
            4:       return 598;
            5:       return 854;
            6:       return 1536;
            7:       return 3072;
            default: return 6144;
        endcase
    endfunction
endpackage

// File: rtl/gen16_period_meter.sv
// Period meter: synchronises the bit clock into the reference domain and
// counts reference cycles between its rising edges. At each edge after the
// first, it emits a one-cycle done pulse with the nearest ratio index.
// Assumes CNT_W is wide enough that saturation lies above the largest threshold.
module gen16_period_meter
    import gen16_pkg::*;
#(
    parameter int unsigned CNT_W = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_clk_async,
    output logic       meas_done,
    output ratio_idx_t meas_idx
);
    localparam logic [CNT_W-1:0] SPAN_MAX = {CNT_W{1'b1}};

    logic [2:0]       bc_sync;
    logic             bc_rise;
    logic [CNT_W-1:0] span;
    logic             armed;
    ratio_idx_t       nearest_idx;

    // Two-flop synchroniser plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) bc_sync <= '0;
        else        bc_sync <= {bc_sync[1:0], bit_clk_async};
    end

    assign bc_rise = bc_sync[1] & ~bc_sync[2];

    // Map the measured span onto the nearest supported ratio
    always_comb begin
        nearest_idx = '0;
        for (int k = 0; k < NUM_RATIOS - 1; k++) begin
            if (32'(span) >= period_threshold(k)) nearest_idx = ratio_idx_t'(k + 1);
        end
    end

    // Span counter with saturation, and the result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            span      <= '0;
            armed     <= 1'b0;
            meas_done <= 1'b0;
            meas_idx  <= '0;
        end else begin
            meas_done <= 1'b0;
            if (bc_rise) begin
                armed <= 1'b1;
                span  <= CNT_W'(1);
                if (armed) begin
                    meas_done <= 1'b1;
                    meas_idx  <= nearest_idx;
                end
            end else if (span != SPAN_MAX) begin
                span <= span + 1'b1;
            end
        end
    end
endmodule

// File: rtl/gen16_ratio_filter.sv
// Agreement filter: the ratio it holds is replaced only when two consecutive
// measurements name the same candidate. Assumes meas_done is a one-cycle pulse.
module gen16_ratio_filter
    import gen16_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       meas_done,
    input  ratio_idx_t meas_idx,
    output ratio_idx_t ratio_idx
);
    ratio_idx_t last_idx;
    logic       last_ok;

    // Remember the previous candidate and commit it when it repeats
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_idx  <= '0;
            last_ok   <= 1'b0;
            ratio_idx <= '0;
        end else if (meas_done) begin
            last_idx <= meas_idx;
            last_ok  <= 1'b1;
            if (last_ok && meas_idx == last_idx) ratio_idx <= meas_idx;
        end
    end
endmodule

// File: rtl/gen16_frac_divider.sv
// Fractional divider: counts down each divide count of the selected ratio's
// pattern and pulses at every reload. If the ratio changes mid-pattern,
// a step index that is out of range restarts at step 0. Held idle while run is low.
module gen16_frac_divider
    import gen16_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  ratio_idx_t ratio_idx,
    output logic       div_tick
);
    logic [DIV_W-1:0] remain;
    logic [PH_W-1:0]  step;
    logic [PH_W-1:0]  step_len;
    logic [PH_W-1:0]  step_eff;
    logic [PH_W-1:0]  step_next;

    // Pick the current and following pattern step for the active ratio
    always_comb begin
        step_len  = pattern_len(ratio_idx);
        step_eff  = (step < step_len) ? step : '0;
        step_next = (step_eff + 1'b1 >= step_len) ? '0 : step_eff + 1'b1;
    end

    // Down-counter that reloads from the pattern and emits the tick
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            remain   <= '0;
            step     <= '0;
            div_tick <= 1'b0;
        end else if (remain == '0) begin
            div_tick <= 1'b1;
            remain   <= divide_count(ratio_idx, step_eff) - 1'b1;
            step     <= step_next;
        end else begin
            div_tick <= 1'b0;
            remain   <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/gen16_ext_edge.sv
// External tick path: synchronises the external 16x clock and registers
// one pulse per rising edge. Assumes high and low phases of at least two
// reference cycles each.
module gen16_ext_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_async,
    output logic ext_tick
);
    logic [2:0] ext_sync;

    // Synchroniser chain with history flop, and the registered edge pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_sync <= '0;
            ext_tick <= 1'b0;
        end else begin
            ext_sync <= {ext_sync[1:0], ext_async};
            ext_tick <= ext_sync[1] & ~ext_sync[2];
        end
    end
endmodule

// File: rtl/gen16_tick_gen.sv
// Top: 16x sample tick generator. auto_sel picks between the measured
// fractional divider and the external 16x clock path. auto_sel is treated
// as a static strap; a change only swaps which registered tick is passed on.
module gen16_tick_gen #(
    parameter int unsigned CNT_W = 14
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        auto_sel,
    input  logic                        bit_clk,
    input  logic                        ext_clk16,
    output logic                        tick,
    output logic [gen16_pkg::IDX_W-1:0] ratio_idx
);
    logic                  meas_done;
    gen16_pkg::ratio_idx_t meas_idx;
    logic                  div_tick;
    logic                  ext_tick;

    gen16_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_clk_async (bit_clk),
        .meas_done     (meas_done),
        .meas_idx      (meas_idx)
    );

    gen16_ratio_filter u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .meas_done (meas_done),
        .meas_idx  (meas_idx),
        .ratio_idx (ratio_idx)
    );

    gen16_frac_divider u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (auto_sel),
        .ratio_idx (ratio_idx),
        .div_tick  (div_tick)
    );

    gen16_ext_edge u_ext (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_async (ext_clk16),
        .ext_tick  (ext_tick)
    );

    // Select the tick source
    assign tick = auto_sel ? div_tick : ext_tick;
endmodule

// File: rtl/gen16_tick_gen_chk.sv
// Property checker for gen16_tick_gen, attached by bind below.
module gen16_tick_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       auto_sel,
    input logic       ext_clk16,
    input logic       tick,
    input logic [3:0] ratio_idx,
    input logic       meas_done,
    input logic [3:0] meas_idx
);
    // R1: index stays inside the ten encoded ratios
    a_r1_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_idx < 4'd10);

    // R5: ratio moves only right after a measurement, to that measurement's value
    a_r5_update_after_meas: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ratio_idx) |-> ($past(meas_done) && ratio_idx == $past(meas_idx)));

    // R7: tick lasts one cycle while the mode is steady
    a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || !$stable(auto_sel)));

    // R6: in external mode a tick traces back to the external clock three cycles earlier
    a_r6_ext_traced: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !auto_sel && !$past(auto_sel) && !$past(auto_sel, 2) && !$past(auto_sel, 3))
        |-> $past(ext_clk16, 3));

    // R8: reset leaves outputs quiet
    a_r8_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!tick && ratio_idx == 4'd0));
endmodule

bind gen16_tick_gen gen16_tick_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .auto_sel  (auto_sel),
    .ext_clk16 (ext_clk16),
    .tick      (tick),
    .ratio_idx (ratio_idx),
    .meas_done (meas_done),
    .meas_idx  (meas_idx)
);

// File: tb/tb_gen16_tick_gen.sv
`timescale 1ns/1ps
module tb_gen16_tick_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       auto_sel = 1'b1;
    logic       bit_clk = 1'b0;
    logic       ext_clk16 = 1'b0;
    logic       tick;
    logic [3:0] ratio_idx;

    int     n_checks = 0;
    int     n_fail = 0;
    longint cyc = 0;
    longint tick_total = 0;
    real    half_ns = 320.0;
    bit     bc_run = 1'b1;
    bit     glitch = 1'b0;
    bit     done = 1'b0;

    gen16_tick_gen dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_sel  (auto_sel),
        .bit_clk   (bit_clk),
        .ext_clk16 (ext_clk16),
        .tick      (tick),
        .ratio_idx (ratio_idx)
    );

    always #2.5 clk = ~clk;

    // Cycle and tick counters, sampled away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (tick) tick_total++;
    end

    // Bit clock source with optional single short period
    initial begin : bitclk_gen
        forever begin
            if (bc_run) begin
                real h;
                h = half_ns;
                if (glitch) begin
                    h = h / 4.0;
                    glitch = 1'b0;
                end
                bit_clk = 1'b1;
                #(h);
                bit_clk = 1'b0;
                #(h);
            end else begin
                #10;
            end
        end
    end

    function automatic int rnum(input int i);
        case (i)
            0: return 8;    1: return 16;   2: return 64;   3: return 128;
            4: return 32;   5: return 128;  6: return 64;   7: return 128;
            8: return 256;  default: return 512;
        endcase
    endfunction

    function automatic int rden(input int i);
        case (i)
            2: return 3;  3: return 5;  5: return 3;  default: return 1;
        endcase
    endfunction

    // Nearest ratio to a bit period given in reference cycles
    function automatic int nearest(input real pcyc);
        int  best = 0;
        real bd = 1.0e9;
        for (int i = 0; i < 10; i++) begin
            real d;
            d = pcyc / 16.0 - real'(rnum(i)) / real'(rden(i));
            if (d < 0.0) d = -d;
            if (d <= bd) begin
                bd = d;
                best = i;
            end
        end
        return best;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_tick();
        int g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!tick && g < 20000);
    endtask

    // Spacing checks for the active ratio (R2 integer, R3 fractional, R7 width)
    task automatic check_intervals(input int idx);
        int den = rden(idx);
        int num = rnum(idx);
        int lo = num / den;
        int hi = (num + den - 1) / den;
        int n = 2 * den + 1;
        int sum = 0;
        int iv[11];
        wait_tick();
        for (int i = 0; i < n; i++) begin
            int c = 0;
            do begin
                @(negedge clk);
                c++;
            end while (!tick && c < 20000);
            iv[i] = c;
        end
        for (int i = 0; i < n; i++) begin
            check(iv[i] == lo || iv[i] == hi, den > 1 ? "R3 spacing" : "R2 spacing", iv[i], lo);
            check(iv[i] > 1, "R7 tick width", iv[i], 2);
        end
        for (int i = 0; i < den; i++) sum += iv[i];
        check(sum == num, den > 1 ? "R3 pattern sum" : "R2 period", sum, num);
    endtask

    // Watchdog
    initial begin : watchdog
        wait (cyc > 195000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 195000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        int          order[10];
        int unsigned seed_v;
        int          bad;
        longint      t0;
        seed_v = $urandom(32'd20240611);

        // R8: reset state
        repeat (4) @(negedge clk);
        check(tick == 1'b0, "R8 tick in reset", tick, 0);
        check(ratio_idx == 4'd0, "R8 ratio in reset", ratio_idx, 0);
        rst_n = 1'b1;

        // R1 R2 R3 R4: sweep all ratios in random order with jitter
        for (int i = 0; i < 10; i++) order[i] = i;
        for (int i = 9; i > 0; i--) begin
            int j;
            int t;
            j = int'($urandom_range(i, 0));
            t = order[i];
            order[i] = order[j];
            order[j] = t;
        end
        for (int k = 0; k < 10; k++) begin
            int  idx;
            int  exp_idx;
            real jit;
            real pcyc;
            idx = order[k];
            jit = (real'($urandom_range(400, 0)) - 200.0) / 10000.0;
            pcyc = 16.0 * real'(rnum(idx)) / real'(rden(idx)) * (1.0 + jit);
            exp_idx = nearest(pcyc);
            @(posedge bit_clk);
            half_ns = pcyc * 5.0 / 2.0;
            @(posedge bit_clk);
            #(3.5 * pcyc * 5.0);
            @(negedge clk);
            check(ratio_idx == 4'(exp_idx), "R1 R4 selected ratio", ratio_idx, exp_idx);
            check_intervals(idx);
        end

        // R5: settle on ratio 32, then inject one short bit period
        @(posedge bit_clk);
        half_ns = 32.0 * 16.0 * 5.0 / 2.0;
        @(posedge bit_clk);
        #(3.5 * 512.0 * 5.0);
        @(negedge clk);
        check(ratio_idx == 4'd4, "R5 settled before glitch", ratio_idx, 4);
        @(posedge bit_clk);
        glitch = 1'b1;
        bad = 0;
        repeat (5 * 512) begin
            @(negedge clk);
            if (ratio_idx != 4'd4) bad++;
        end
        check(bad == 0, "R5 single glitch ignored", bad, 0);
        check_intervals(4);

        // R9: stop the bit clock past counter saturation
        @(posedge bit_clk);
        bc_run = 1'b0;
        bad = 0;
        repeat (17000) begin
            @(negedge clk);
            if (ratio_idx != 4'd4) bad++;
        end
        check(bad == 0, "R9 ratio held while stopped", bad, 0);
        bc_run = 1'b1;

        // R6: external mode, no external edges gives no ticks
        @(negedge clk);
        auto_sel = 1'b0;
        repeat (10) @(negedge clk);
        t0 = tick_total;
        repeat (300) @(negedge clk);
        check(tick_total == t0, "R6 no ticks without edges", tick_total - t0, 0);

        // R6: latency from an edge launched at a falling reference edge
        ext_clk16 = 1'b1;
        bad = 0;
        do begin
            @(negedge clk);
            bad++;
        end while (!tick && bad < 50);
        check(bad == 3, "R6 latency", bad, 3);
        repeat (3) @(negedge clk);
        ext_clk16 = 1'b0;
        repeat (5) @(negedge clk);

        // R6: random edge train, one tick per rising edge
        t0 = tick_total;
        for (int i = 0; i < 20; i++) begin
            ext_clk16 = 1'b1;
            repeat (int'($urandom_range(6, 2))) @(negedge clk);
            ext_clk16 = 1'b0;
            repeat (int'($urandom_range(6, 2))) @(negedge clk);
        end
        repeat (10) @(negedge clk);
        check(tick_total - t0 == 20, "R6 tick per edge", tick_total - t0, 20);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule